// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller

This block gathers interrupt requests for a small shared-memory multiprocessor and gives each processor one prioritized request level. Fifteen primary sources (numbered 1 to 15) are latched on rising edges into a shared pending set. A separate force set lets software raise any source. A write-one-to-clear word removes requests from both sets. Each processor has its own enable mask, so one request can be steered to some processors and hidden from others. The level a processor sees is the highest-numbered request that its mask enables, and a processor that sees a request clears it with a single-cycle acknowledge pulse.

When the parameter `EXT_LINE` is non-zero, sixteen further sources (16 to 31) are enabled. Any of them that a processor's mask enables shows up to that processor as primary level `EXT_LINE`. When the processor acknowledges that level, the controller writes the extended source number into that processor's ID word and retires only that one source. A plain synchronous register port gives access to the sets, the masks, the ID words and a fixed status word that reports the processor count.

Top module: `mp_irq_ctrl`

## Requirements
- R1: After reset every level output is 0, and the pending, force, mask and ID words all read 0.
- R2: A 0-to-1 transition on `irq_in[n]` sets bit n of the pending word (read at offset 0x00) on the clock edge where the high value is first sampled. A line that stays high does not set the bit again after it has been cleared.
- R3: Writing offset 0x04 sets the force bits that are 1 in the written word and leaves the others unchanged. The force word reads back at 0x04. A force bit counts as a request on its line, but it does not appear in the pending word.
- R4: Writing offset 0x08 clears the pending and force bits that are 1 in the written word and leaves the others unchanged.
- R5: Processor c has a mask word at offset 0x40+4c. Bit n = 1 lets source n reach that processor. Bit 0 cannot be set and always reads 0.
- R6: The 4-bit level of processor c (`cpu_level[4c+3:4c]`) is the highest-numbered source that is pending or forced and also enabled by that processor's mask. It is 0 when no source qualifies.
- R7: A one-cycle `cpu_ack[c]` clears the pending and force bits of the level that processor c is presented with in that cycle. It does not touch any other source, and a level of 0 makes the acknowledge do nothing.
- R8: With `EXT_LINE` non-zero, any source from 16 to 31 that is pending or forced and enabled by processor c makes primary source `EXT_LINE` count as requesting for processor c. Higher primary sources still win over it.
- R9: When processor c acknowledges level `EXT_LINE` while an extended source qualifies, its ID word (offset 0x80+4c, bits 4:0) takes the highest qualifying extended number, which has bit 4 set, and only that extended source is cleared. If no extended source qualifies, the ID word takes `EXT_LINE` (bit 4 clear) and primary source `EXT_LINE` is cleared.
- R10: The status word at offset 0x0C holds NCPU-1 in bits 31:28 and the `BCAST` parameter in bit 27. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Interrupt request lines. Bit n is source n; bit 0 is unused, and bits 31:16 are used only when EXT_LINE is non-zero |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the access |
| cpu_level | output | 4*NCPU | Request level for each processor, 4 bits each |
| cpu_ack | input | NCPU | One-cycle acknowledge from each processor |

## Verification
The bench builds the block with NCPU = 2, EXT_LINE = 12 and BCAST = 1. With two processors, one processor's mask can be shown to hide a request that the other processor sees and acknowledges. With extended sources folded behind line 12, both cases can be tested: a primary source above 12 pre-empting the extended group, and the ID word taking both valid extended numbers and the bare primary number 12. BCAST = 1 together with NCPU = 2 gives a status word with both of its fields non-zero.

// File: rtl/mp_irq_ctrl.sv
module mp_irq_ctrl #(
  parameter int NCPU     = 2,
  parameter int EXT_LINE = 12,
  parameter bit BCAST    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       irq_in,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NCPU*4-1:0] cpu_level,
  input  logic [NCPU-1:0]   cpu_ack
);

  localparam logic [31:0] LMASK = (EXT_LINE != 0) ? 32'hFFFF_FFFE : 32'h0000_FFFE;
  localparam logic [3:0]  XL    = 4'(EXT_LINE);

  function automatic logic [3:0] top_idx(input logic [15:0] v);
    top_idx = 4'd0;
    for (int k = 0; k < 16; k++)
      if (v[k]) top_idx = 4'(k);
  endfunction

  logic [31:0] irq_q, pend_q, frc_q, eff, rise, clr_all;
  logic [31:0] mask_q  [NCPU];
  logic [4:0]  id_q    [NCPU];
  logic [31:0] ack_clr [NCPU];
  logic [3:0]  lvl     [NCPU];
  logic [3:0]  ext_idx [NCPU];
  logic [NCPU-1:0] ext_hit;

  wire wr     = bus_sel && bus_we;
  wire frc_we = wr && bus_addr == 8'h04;
  wire clr_we = wr && bus_addr == 8'h08;

  assign rise = irq_in & ~irq_q & LMASK;
  assign eff  = pend_q | frc_q;

  for (genvar i = 0; i < NCPU; i++) begin : g_cpu
    logic [31:0] en;
    logic [15:0] prim;
    assign en         = eff & mask_q[i];
    assign ext_hit[i] = (EXT_LINE != 0) && (|en[31:16]);
    assign ext_idx[i] = top_idx(en[31:16]);
    assign prim       = en[15:0] | (16'(ext_hit[i]) << EXT_LINE);
    assign lvl[i]     = top_idx(prim);
    assign cpu_level[i*4 +: 4] = lvl[i];

    always_comb begin
      ack_clr[i] = '0;
      if (cpu_ack[i] && lvl[i] != 4'd0) begin
        if (EXT_LINE != 0 && lvl[i] == XL && ext_hit[i])
          ack_clr[i] = 32'd1 << (5'd16 + 5'(ext_idx[i]));
        else
          ack_clr[i] = 32'd1 << lvl[i];
      end
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) id_q[i] <= '0;
      else if (EXT_LINE != 0 && cpu_ack[i] && lvl[i] == XL)
        id_q[i] <= ext_hit[i] ? {1'b1, ext_idx[i]} : 5'(EXT_LINE);

    // R6
    level_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl[i] != 4'd0 && lvl[i] != XL) |-> (mask_q[i][lvl[i]] && eff[lvl[i]]));

    // R7
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ack[i] && lvl[i] != 4'd0 && lvl[i] != XL && !wr && !rise[lvl[i]])
      |=> ((eff & (32'd1 << $past(lvl[i]))) == 32'd0));

    // R9
    ext_id_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (EXT_LINE != 0 && cpu_ack[i] && lvl[i] == XL && ext_hit[i]) |=> id_q[i][4]);
  end

  always_comb begin
    clr_all = clr_we ? bus_wdata : 32'd0;
    for (int c = 0; c < NCPU; c++) clr_all = clr_all | ack_clr[c];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irq_q  <= '0;
      pend_q <= '0;
      frc_q  <= '0;
      for (int c = 0; c < NCPU; c++) mask_q[c] <= '0;
    end else begin
      irq_q  <= irq_in;
      pend_q <= ((pend_q & ~clr_all) | rise) & LMASK;
      frc_q  <= ((frc_q & ~clr_all) | (frc_we ? bus_wdata : 32'd0)) & LMASK;
      for (int c = 0; c < NCPU; c++)
        if (wr && bus_addr == 8'(8'h40 + 4*c)) mask_q[c] <= bus_wdata & LMASK;
    end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      8'h00: bus_rdata = pend_q;
      8'h04: bus_rdata = frc_q;
      8'h0C: bus_rdata = {4'(NCPU - 1), BCAST, 27'd0};
      default: ;
    endcase
    for (int c = 0; c < NCPU; c++) begin
      if (bus_addr == 8'(8'h40 + 4*c)) bus_rdata = mask_q[c];
      if (bus_addr == 8'(8'h80 + 4*c)) bus_rdata = {27'd0, id_q[c]};
    end
  end

  // R4
  clear_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((eff & $past(bus_wdata & ~rise)) == 32'd0));

  // R2
  edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != 32'd0) |=> ((pend_q & $past(rise)) == $past(rise)));

endmodule

// File: tb/mp_irq_ctrl_test.sv
module mp_irq_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic [31:0] irq_in = 0, bus_wdata = 0;
  logic bus_sel = 0, bus_we = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_rdata;
  logic [7:0] cpu_level;
  logic [1:0] cpu_ack = 0;
  int nchk = 0, nfail = 0;

  mp_irq_ctrl #(.NCPU(2), .EXT_LINE(12), .BCAST(1'b1)) uut (
    .clk, .rst_n, .irq_in, .bus_sel, .bus_we, .bus_addr, .bus_wdata,
    .bus_rdata, .cpu_level, .cpu_ack);

  always #4 clk = ~clk;

  initial begin
    #1_000_000;
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic pulse(logic [31:0] m);
    @(negedge clk); irq_in = irq_in | m;
    @(negedge clk); irq_in = irq_in & ~m;
  endtask

  task automatic ack(logic [1:0] c);
    @(negedge clk); cpu_ack = c;
    @(negedge clk); cpu_ack = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    @(negedge clk);
    chk("R1 levels", 32'(cpu_level), 0);
    rd(8'h00, d); chk("R1 pend", d, 0);
    rd(8'h04, d); chk("R1 force", d, 0);
    rd(8'h40, d); chk("R1 mask0", d, 0);
    rd(8'h80, d); chk("R1 id0", d, 0);
    rd(8'h0C, d); chk("R10 status", d, 32'h1800_0000);
  endtask

  task automatic t_edge;
    logic [31:0] d;
    pulse(32'h20);
    rd(8'h00, d); chk("R2 pend bit5", d, 32'h20);
    chk("R5 masked level0", 32'(cpu_level[3:0]), 0);
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, d); chk("R5 mask bit0 reads 0", d, 32'hFFFF_FFFE);
    wr(8'h40, 32'h20);
    chk("R6 level0 5", 32'(cpu_level[3:0]), 5);
    chk("R5 level1 masked", 32'(cpu_level[7:4]), 0);
    @(negedge clk); irq_in[7] = 1;
    @(negedge clk); irq_in[7] = 0;
    wr(8'h08, 32'h20);
    rd(8'h00, d); chk("R4 clear keeps bit7", d, 32'h80);
    @(negedge clk); irq_in[9] = 1;
    wr(8'h08, 32'h280);
    repeat (3) @(negedge clk);
    rd(8'h00, d); chk("R2 held line no reset", d, 0);
    irq_in[9] = 0;
  endtask

  task automatic t_prio;
    wr(8'h40, 32'hFFFE);
    pulse(32'h208);
    chk("R6 highest 9", 32'(cpu_level[3:0]), 9);
    ack(2'b01);
    chk("R7 ack leaves 3", 32'(cpu_level[3:0]), 3);
    ack(2'b01);
    chk("R7 ack to 0", 32'(cpu_level[3:0]), 0);
  endtask

  task automatic t_force;
    logic [31:0] d;
    wr(8'h04, 32'h80);
    wr(8'h04, 32'h10);
    rd(8'h04, d); chk("R3 force read", d, 32'h90);
    rd(8'h00, d); chk("R3 pend not shown", d, 0);
    chk("R3 forced level", 32'(cpu_level[3:0]), 7);
    wr(8'h08, 32'h80);
    rd(8'h04, d); chk("R4 clear force", d, 32'h10);
    ack(2'b01);
    rd(8'h04, d); chk("R7 ack clears force", d, 0);
  endtask

  task automatic t_percpu;
    wr(8'h44, 32'h4);
    pulse(32'h44);
    chk("R5 cpu0 sees 6", 32'(cpu_level[3:0]), 6);
    chk("R5 cpu1 sees 2", 32'(cpu_level[7:4]), 2);
    ack(2'b10);
    chk("R7 cpu1 cleared", 32'(cpu_level[7:4]), 0);
    chk("R7 cpu0 untouched", 32'(cpu_level[3:0]), 6);
    ack(2'b01);
    chk("R7 cpu0 cleared", 32'(cpu_level[3:0]), 0);
  endtask

  task automatic t_ext;
    logic [31:0] d;
    wr(8'h40, 32'hFFFF_FFFE);
    wr(8'h44, 32'h1000);
    pulse(32'h0012_0000);
    chk("R8 ext folds to 12", 32'(cpu_level[3:0]), 12);
    chk("R8 cpu1 no ext mask", 32'(cpu_level[7:4]), 0);
    ack(2'b01);
    rd(8'h80, d); chk("R9 id 20", d, 32'h14);
    chk("R9 17 remains", 32'(cpu_level[3:0]), 12);
    ack(2'b01);
    rd(8'h80, d); chk("R9 id 17", d, 32'h11);
    rd(8'h00, d); chk("R9 ext cleared", d, 0);
    pulse(32'h1000);
    chk("R8 cpu1 line12", 32'(cpu_level[7:4]), 12);
    ack(2'b10);
    rd(8'h84, d); chk("R9 bare id 12", d, 32'h0C);
    chk("R9 line12 cleared", 32'(cpu_level[3:0]), 0);
    pulse(32'h0200_4000);
    chk("R8 primary 14 wins", 32'(cpu_level[3:0]), 14);
    ack(2'b01);
    chk("R8 then ext", 32'(cpu_level[3:0]), 12);
    ack(2'b01);
    rd(8'h80, d); chk("R9 id 25", d, 32'h19);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_edge;
    t_prio;
    t_force;
    t_percpu;
    t_ext;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule